// File: doc/BRIEF.md
# Gated-OR Register Bus Fabric

This block links a single bus master to a parameterized set of slave register blocks over two one-way data paths. The master puts an address on the bus together with a write strobe or a read strobe. Write data goes out to every slave unchanged. Each slave gets a write enable and a read enable. These are asserted only when the address falls inside that slave's window.

For a read, each slave places its data on its own return lane. The fabric never selects a lane by index. Each lane is ANDed with that slave's decode select, and the gated lane is stored in a register. A wide OR then merges the registered lanes into the single value the master sees. Slaves that are not selected, and slots that are not populated, add only zeros to the OR. The result arrives one cycle after the read strobe, with a matching valid flag.

Each slave slot has a fixed address window. The window starts at a base address plus the slot index times a stride, and it has a set size. A presence mask marks which slots hold a slave. An absent slot is never selected, so it has no effect on the returned data or on any write enable.

Top module: `rbus_or_fabric`

## Requirements
- R1: Slot i is selected only when bit i of the presence mask is set and BASE + i*STRIDE <= address < BASE + i*STRIDE + WIN. At most one slot is selected at a time.
- R2: In the same cycle, slave write enable i equals the master write strobe ANDed with the select of slot i.
- R2: The broadcast write data always equals the master write data.
- R3: In the same cycle, slave read enable i equals the master read strobe ANDed with the select of slot i.
- R4: The read-valid output is high in exactly the cycle after a cycle with the read strobe high, and low otherwise.
- R5: In the cycle after a read, the master read data equals the read lane of the selected slave as it was in the read cycle. Later changes on the lanes do not alter it.
- R6: A read or write to an address outside every window, or inside the window of an absent slot, raises no enable. Such a read returns zero with read-valid high.
- R7: Whenever read-valid is low, the master read data is zero.
- R8: After reset, read-valid is low and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_addr | input | AW | Master address |
| m_wr | input | 1 | Master write strobe |
| m_rd | input | 1 | Master read strobe |
| m_wdata | input | DW | Master write data |
| m_rdata | output | DW | Merged read data |
| m_rvalid | output | 1 | Read data valid, one cycle after m_rd |
| s_wdata | output | DW | Write data broadcast to all slaves |
| s_we | output | NSLV | Per-slave write enable |
| s_re | output | NSLV | Per-slave read enable |
| s_rdata | input | NSLV*DW | Slave read lanes, slot i at bits [i*DW +: DW] |

## Verification
Enables and broadcast write data are combinational. They are due in the cycle the strobe is presented, so the bench checks them shortly after it drives the inputs on the falling edge, before the next rising edge. Read-valid and read data come through one register stage. The bench checks them at the falling edge after the capturing rising edge. Just before that check it scrambles every slave lane, which shows the value was captured rather than passed through. One cycle later the bench checks that valid has dropped and the data has returned to zero.

// File: rtl/rbus_pkg.sv
package rbus_pkg;

  // Start of slot i's window.
  function automatic logic [31:0] slot_base(input int unsigned idx,
                                            input logic [31:0] base0,
                                            input logic [31:0] stride);
    return base0 + stride * 32'(idx);
  endfunction

  // Half-open window test, widened so base+size cannot wrap.
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input logic [31:0] size);
    logic [32:0] lo, hi, x;
    lo = {1'b0, base};
    hi = {1'b0, base} + {1'b0, size};
    x  = {1'b0, a};
    return (x >= lo) && (x < hi);
  endfunction

endpackage

// File: rtl/rbus_decode.sv
module rbus_decode
  import rbus_pkg::*;
#(
  parameter int unsigned NSLV = 4,
  parameter int unsigned AW = 12,
  parameter logic [31:0] BASE = 32'h100,
  parameter logic [31:0] STRIDE = 32'h40,
  parameter logic [31:0] WIN = 32'h20,
  parameter logic [NSLV-1:0] PRESENT = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  output logic [NSLV-1:0] sel
);

  logic [31:0] addr_w;
  assign addr_w = 32'(addr);

  for (genvar i = 0; i < NSLV; i++) begin : g_slot
    assign sel[i] = PRESENT[i] &&
                    in_window(addr_w, slot_base(i, BASE, STRIDE), WIN);
  end

  // R1: windows never overlap
  a_r1_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

endmodule

// File: rtl/rbus_gate_stage.sv
module rbus_gate_stage #(
  parameter int unsigned NSLV = 4,
  parameter int unsigned DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd,
  input  logic [NSLV-1:0]    sel,
  input  logic [NSLV*DW-1:0] lanes_in,
  output logic [NSLV*DW-1:0] lanes_q,
  output logic               rvalid
);

  logic [NSLV-1:0] lane_live;

  for (genvar i = 0; i < NSLV; i++) begin : g_lane
    logic [DW-1:0] gated;
    assign gated = (rd && sel[i]) ? lanes_in[i*DW +: DW] : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lanes_q[i*DW +: DW] <= '0;
      else        lanes_q[i*DW +: DW] <= gated;
    end
    assign lane_live[i] = |lanes_q[i*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= rd;
  end

  // R5: only the one selected lane may carry data after gating
  a_r5_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_live));

  // R7: nothing is captured without a read
  a_r7_lanes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (lane_live == '0));

endmodule

// File: rtl/rbus_or_tree.sv
module rbus_or_tree #(
  parameter int unsigned NSLV = 4,
  parameter int unsigned DW = 16
) (
  input  logic [NSLV*DW-1:0] lanes,
  output logic [DW-1:0]      merged
);

  logic [DW-1:0] acc [NSLV+1];
  assign acc[0] = '0;

  for (genvar i = 0; i < NSLV; i++) begin : g_or
    assign acc[i+1] = acc[i] | lanes[i*DW +: DW];
  end

  assign merged = acc[NSLV];

endmodule

// File: rtl/rbus_or_fabric.sv
module rbus_or_fabric #(
  parameter int unsigned NSLV = 4,
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16,
  parameter logic [31:0] BASE = 32'h100,
  parameter logic [31:0] STRIDE = 32'h40,
  parameter logic [31:0] WIN = 32'h20,
  parameter logic [NSLV-1:0] PRESENT = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      m_addr,
  input  logic               m_wr,
  input  logic               m_rd,
  input  logic [DW-1:0]      m_wdata,
  output logic [DW-1:0]      m_rdata,
  output logic               m_rvalid,
  output logic [DW-1:0]      s_wdata,
  output logic [NSLV-1:0]    s_we,
  output logic [NSLV-1:0]    s_re,
  input  logic [NSLV*DW-1:0] s_rdata
);

  logic [NSLV-1:0]    sel;
  logic [NSLV*DW-1:0] lanes_q;

  rbus_decode #(
    .NSLV(NSLV), .AW(AW), .BASE(BASE), .STRIDE(STRIDE),
    .WIN(WIN), .PRESENT(PRESENT)
  ) i_decode (
    .clk(clk), .rst_n(rst_n), .addr(m_addr), .sel(sel)
  );

  assign s_wdata = m_wdata;
  assign s_we    = sel & {NSLV{m_wr}};
  assign s_re    = sel & {NSLV{m_rd}};

  rbus_gate_stage #(.NSLV(NSLV), .DW(DW)) i_gate (
    .clk(clk), .rst_n(rst_n), .rd(m_rd), .sel(sel),
    .lanes_in(s_rdata), .lanes_q(lanes_q), .rvalid(m_rvalid)
  );

  rbus_or_tree #(.NSLV(NSLV), .DW(DW)) i_or (
    .lanes(lanes_q), .merged(m_rdata)
  );

  // R2: no write enable without the write strobe
  a_r2_we_needs_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (s_we != '0) |-> m_wr);

  // R3: no read enable without the read strobe
  a_r3_re_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (s_re != '0) |-> m_rd);

  // R4: valid follows a read by one cycle
  a_r4_valid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    m_rd |=> m_rvalid);

  // R4: no valid without a preceding read
  a_r4_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !m_rd |=> !m_rvalid);

  // R7: merged data idles at zero
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !m_rvalid |-> (m_rdata == '0));

endmodule

// File: tb/test_rbus_or_fabric.sv
`timescale 1ns/1ps
module test_rbus_or_fabric;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam logic [31:0] B0  = 32'h100;
  localparam logic [31:0] STP = 32'h40;
  localparam logic [31:0] WSZ = 32'h20;
  localparam logic [N-1:0] PRES = 4'b1011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic m_wr = 1'b0, m_rd = 1'b0;
  logic [DW-1:0] m_wdata = '0;
  logic [DW-1:0] m_rdata;
  logic m_rvalid;
  logic [DW-1:0] s_wdata;
  logic [N-1:0] s_we, s_re;
  logic [N*DW-1:0] s_rdata = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rbus_or_fabric #(
    .NSLV(N), .AW(AW), .DW(DW), .BASE(B0), .STRIDE(STP),
    .WIN(WSZ), .PRESENT(PRES)
  ) i_rbus_or_fabric (
    .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd),
    .m_wdata(m_wdata), .m_rdata(m_rdata), .m_rvalid(m_rvalid),
    .s_wdata(s_wdata), .s_we(s_we), .s_re(s_re), .s_rdata(s_rdata)
  );

  // Expected slot for an address, -1 when none
  function automatic int exp_slot(input logic [AW-1:0] a);
    int av;
    av = int'(a);
    for (int k = 0; k < N; k++) begin
      int lo;
      lo = int'(B0) + k * int'(STP);
      if (PRES[k] && av >= lo && av < lo + int'(WSZ)) return k;
    end
    return -1;
  endfunction

  function automatic logic [N-1:0] exp_mask(input int s, input logic strobe);
    logic [N-1:0] m;
    m = '0;
    if (strobe && s >= 0) m[s] = 1'b1;
    return m;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scramble_lanes();
    for (int k = 0; k < N; k++)
      s_rdata[k*DW +: DW] = DW'($urandom) | DW'(1 << k);
  endtask

  task automatic do_op(input logic [AW-1:0] a, input logic wr, input logic rd);
    int s;
    logic [DW-1:0] want;
    s = exp_slot(a);
    @(negedge clk);
    m_addr = a; m_wr = wr; m_rd = rd; m_wdata = DW'($urandom);
    scramble_lanes();
    want = (rd && s >= 0) ? s_rdata[s*DW +: DW] : '0;
    #1;
    chk(s_we == exp_mask(s, wr), "R2 we", 32'(s_we), 32'(exp_mask(s, wr)));
    chk(s_wdata == m_wdata, "R2 wdata", 32'(s_wdata), 32'(m_wdata));
    chk(s_re == exp_mask(s, rd), "R3 re", 32'(s_re), 32'(exp_mask(s, rd)));
    if (s < 0) chk((s_we | s_re) == '0, "R6 no enable", 32'(s_we | s_re), 0);
    @(negedge clk);
    scramble_lanes();
    #1;
    chk(m_rvalid == rd, "R4 rvalid", 32'(m_rvalid), 32'(rd));
    if (rd) chk(m_rdata == want, (s < 0) ? "R6 zero read" : "R5 rdata",
                32'(m_rdata), 32'(want));
    else    chk(m_rdata == '0, "R7 idle data", 32'(m_rdata), 0);
    m_wr = 1'b0; m_rd = 1'b0;
    @(negedge clk);
    #1;
    chk(m_rvalid == 1'b0, "R4 valid drop", 32'(m_rvalid), 0);
    chk(m_rdata == '0, "R7 zero after", 32'(m_rdata), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1;
    chk(m_rvalid == 1'b0, "R8 reset valid", 32'(m_rvalid), 0);
    chk(m_rdata == '0, "R8 reset data", 32'(m_rdata), 0);
    rst_n = 1'b1;
    // R1 directed window edges for every slot
    for (int k = 0; k < N; k++) begin
      int lo;
      lo = int'(B0) + k * int'(STP);
      do_op(AW'(lo), 1'b0, 1'b1);
      do_op(AW'(lo + int'(WSZ) - 1), 1'b1, 1'b1);
      do_op(AW'(lo + int'(WSZ)), 1'b0, 1'b1);
      do_op(AW'(lo - 1), 1'b1, 1'b0);
    end
    // R6 absent slot and far address
    do_op(AW'(32'h190), 1'b1, 1'b1);
    do_op(AW'(0), 1'b0, 1'b1);
    do_op(AW'(32'hFFF), 1'b1, 1'b1);
    // Constrained random mix around the windows
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      a = AW'(32'h0F0 + ($urandom % 32'h120));
      do_op(a, 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule